// File: doc/BRIEF.md
# Wakeup Interrupt Polarity Normalizer

This block sits in an always-on power domain. On one side are a set of wakeup-capable interrupt pins. On the other side is an interrupt controller that understands only rising edges and active-high levels. Each pin has a 3-bit sense code, written through a simple register port. The code states how the pin signals an interrupt: a low or high level, a falling or rising edge, or both edges. The block synchronizes each pin and converts it into the form the controller accepts. Low levels are inverted into high levels. Falling edges and dual edges become one-cycle pulses. The result is gated by a per-pin enable bit.

When the processor domain is powered down (`dom_sleep` high), edge events are not sent downstream. They are latched as pending bits instead, and the block raises `wake_o`. Once the domain reports that it is ready, `wake_o` drops and the latched edges are replayed as single pulses, one pin per cycle. Routing to parent interrupt numbers and power sequencing are handled elsewhere.

Top module: `wake_irq_normalizer`

## Requirements
- R1: Each pin passes through a two-flop synchronizer. A level change on `pin_i` shows on `irq_o` after the second rising clock edge, and every edge-derived pulse lasts exactly one cycle.
- R2: Sense code 4 drives the pin's input level unchanged to `irq_o`. Sense code 0 drives the inverted level, so a low input gives a high output.
- R3: Sense code 6 gives a one-cycle pulse on each rising input transition. Sense code 2 gives a one-cycle pulse on each falling input transition. A level held steady gives no output.
- R4: Sense code 7 gives a one-cycle pulse on every input transition, in either direction.
- R5: Sense codes 1, 3 and 5 hold the pin's output at 0, whatever the input does.
- R6: Enable bits sit in 32-bit words at byte offset 0x10 + 4*w. Pin p uses word p/32, bit p%32. A write takes effect on the clock edge that stores it. A disabled pin drives 0 on `irq_o` and holds no pending state.
- R7: The configuration word of pin p is at byte offset 0x110 + 4*p, with the sense code in bits [2:0]. Reads return the stored code zero-extended, or the enable word with bits above the pin count at 0. Any other address reads 0.
- R8: While `dom_sleep` is high, edge events of enabled pins do not appear on `irq_o`. Each one sets the pin's pending bit instead. While `dom_sleep` is low, no pending bit is set.
- R9: While `dom_sleep` is high and `dom_ready` is low, `wake_o` rises on the clock edge after any pending bit is set or any enabled level-sensed pin is active. It then stays high until `dom_ready`.
- R10: `dom_ready` high at a clock edge clears `wake_o` at that edge, and this takes priority over setting it.
- R11: While `dom_ready` is high and `dom_sleep` is low, pending pins are replayed one per cycle, lowest index first. Each replay is a one-cycle pulse on `irq_o`, and the pin's pending bit is cleared at the edge ending that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPINS | Raw wakeup interrupt pins, asynchronous |
| reg_addr | input | 12 | Register byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| dom_sleep | input | 1 | High while the processor domain is powered down |
| dom_ready | input | 1 | High once the processor domain is up and can take interrupts |
| irq_o | output | NPINS | Normalized active-high levels and rising-edge pulses to the interrupt controller |
| wake_o | output | 1 | Wake request to the power sequencer |

## Verification
A wrong sense decode or a wrong synchronizer stage shows on `irq_o` within three cycles of an input change, as a pulse that is missing, extra or moved. Every sense code is swept against every pair of input values to catch this. A pending bit that is wrongly set or left set has no effect until replay. It then shows as an extra or missing pulse, or as pulses in the wrong order, in the cycles right after `dom_ready` rises. A wake latch that is set or cleared wrongly shows on `wake_o` one cycle after the event that should have changed it.

// File: rtl/wake_irq_normalizer.sv
module wake_irq_normalizer #(
  parameter int NPINS    = 8,
  parameter int EN_BASE  = 'h010,
  parameter int CFG_BASE = 'h110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic [11:0]      reg_addr,
  input  logic             reg_we,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             dom_sleep,
  input  logic             dom_ready,
  output logic [NPINS-1:0] irq_o,
  output logic             wake_o
);

  localparam int NWORDS = (NPINS + 31) / 32;

  logic [NPINS-1:0]      s1_q, s2_q, s3_q;
  logic [NPINS-1:0]      en_q, pend_q;
  logic [NPINS-1:0][2:0] cfg_q;
  logic [NPINS-1:0]      lvl, ev, rp;
  logic                  wake_q;

  function automatic logic [1:0] sense(input logic [2:0] c, input logic cur, input logic prv);
    case (c)
      3'd0:    sense = {~cur, 1'b0};
      3'd4:    sense = { cur, 1'b0};
      3'd2:    sense = {1'b0, ~cur & prv};
      3'd6:    sense = {1'b0, cur & ~prv};
      3'd7:    sense = {1'b0, cur ^ prv};
      default: sense = 2'b00;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      cfg_q <= '0;
    end else if (reg_we) begin
      for (int p = 0; p < NPINS; p++) begin
        if (reg_addr == 12'(EN_BASE + 4 * (p / 32))) en_q[p] <= reg_wdata[p % 32];
        if (reg_addr == 12'(CFG_BASE + 4 * p)) cfg_q[p] <= reg_wdata[2:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < NWORDS; w++)
      if (reg_addr == 12'(EN_BASE + 4 * w))
        for (int b = 0; b < 32; b++)
          if (w * 32 + b < NPINS) reg_rdata[b] = en_q[w * 32 + b];
    for (int p = 0; p < NPINS; p++)
      if (reg_addr == 12'(CFG_BASE + 4 * p)) reg_rdata = {29'd0, cfg_q[p]};
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign {lvl[p], ev[p]} = sense(cfg_q[p], s2_q[p], s3_q[p]);
  end

  assign rp    = (dom_ready && !dom_sleep) ? (pend_q & (~pend_q + 1'b1)) : '0;
  assign irq_o = en_q & (lvl | (ev & {NPINS{~dom_sleep}}) | rp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      wake_q <= 1'b0;
    end else begin
      pend_q <= ((pend_q & ~rp) | (ev & {NPINS{dom_sleep}})) & en_q;
      if (dom_ready) wake_q <= 1'b0;
      else if (dom_sleep && |(pend_q | (lvl & en_q))) wake_q <= 1'b1;
    end
  end

  assign wake_o = wake_q;

endmodule

module wake_irq_normalizer_chk #(
  parameter int NPINS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  dom_sleep,
  input logic                  dom_ready,
  input logic                  wake_o,
  input logic [NPINS-1:0]      irq_o,
  input logic [NPINS-1:0]      pend_q,
  input logic [NPINS-1:0]      rp,
  input logic [NPINS-1:0][2:0] cfg_q
);

  AST_WAKE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    dom_ready |=> !wake_o); // R10

  AST_WAKE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_sleep && !dom_ready && pend_q != '0) |=> wake_o); // R9

  AST_NO_PEND_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !dom_sleep |=> ((pend_q & ~$past(pend_q)) == '0)); // R8

  AST_REPLAY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rp != '0) |=> ((pend_q & $past(rp)) == '0)); // R11

  for (genvar p = 0; p < NPINS; p++) begin : g_unused
    AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[p] == 3'd1 || cfg_q[p] == 3'd3 || cfg_q[p] == 3'd5) |-> !irq_o[p]); // R5
  end

endmodule

bind wake_irq_normalizer wake_irq_normalizer_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .dom_sleep(dom_sleep), .dom_ready(dom_ready),
  .wake_o(wake_o), .irq_o(irq_o), .pend_q(pend_q), .rp(rp), .cfg_q(cfg_q)
);

// File: tb/wake_irq_normalizer_tb.sv
module wake_irq_normalizer_tb_top;
  localparam int NP = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_i = '0;
  logic [11:0]   reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          dom_sleep = 1'b0;
  logic          dom_ready = 1'b0;
  logic [NP-1:0] irq_o;
  logic          wake_o;

  int checks = 0;
  int errors = 0;
  int en0 = 0;

  always #4 clk = ~clk;

  wake_irq_normalizer #(.NPINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dom_sleep(dom_sleep),
    .dom_ready(dom_ready), .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = '0;
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
    reg_addr = '0;
  endtask

  function automatic logic lvl_exp(input int c, input logic v);
    return (c == 4) ? v : (c == 0) ? !v : 1'b0;
  endfunction

  function automatic logic edge_exp(input int c, input logic a, input logic b);
    case (c)
      6: return !a && b;
      2: return a && !b;
      7: return a != b;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p3, p34, order_ok;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    check("R6 reset irq", irq_o, '0);
    check("R9 reset wake", wake_o, 1'b0);
    rd("R6 reset enable word", 12'h010, 32'd0);
    rd("R7 reset cfg", 12'h110, 32'd0);

    // R7 register readback
    wr(12'h110 + 12'd4 * 12'd34, 32'hFFFF_FFFD);
    rd("R7 cfg readback pin34", 12'h110 + 12'd4 * 12'd34, 32'd5);
    wr(12'h014, 32'hFFFF_FFFF);
    rd("R7 enable word1 readback", 12'h014, 32'h0000_000F);
    rd("R7 unmapped read", 12'h000, 32'd0);
    wr(12'h014, 32'd0);
    wr(12'h110 + 12'd4 * 12'd34, 32'd0);

    // R1 R2 R3 R4 R5 sweep of all codes on pin 3
    en0 = 1 << 3;
    wr(12'h010, en0);
    for (int c = 0; c < 8; c++) begin
      for (int ab = 0; ab < 4; ab++) begin
        logic a, b;
        a = ab[1]; b = ab[0];
        pin_i[3] = a;
        wr(12'h110 + 12'd12, c);
        cyc(4);
        check($sformatf("R2 R5 steady code %0d in %0d", c, a), irq_o[3], lvl_exp(c, a));
        pin_i[3] = b;
        cyc(2);
        check($sformatf("R1 R3 R4 after change code %0d %0d->%0d", c, a, b), irq_o[3],
              lvl_exp(c, b) | edge_exp(c, a, b));
        cyc(1);
        check($sformatf("R1 one-cycle pulse code %0d %0d->%0d", c, a, b), irq_o[3], lvl_exp(c, b));
      end
    end
    pin_i[3] = 1'b0;

    // R6 disabled pin stays quiet
    wr(12'h110 + 12'd20, 32'd7);
    for (int k = 0; k < 6; k++) begin
      pin_i[5] = ~pin_i[5];
      cyc(1);
      check("R6 disabled pin output", irq_o[5], 1'b0);
    end
    pin_i[5] = 1'b0;
    wr(12'h110 + 12'd20, 32'd6);

    // R6 enable takes effect at the storing edge
    wr(12'h110 + 12'd36, 32'd4);
    pin_i[9] = 1'b1;
    cyc(4);
    @(negedge clk);
    reg_addr = 12'h010; reg_wdata = en0 | (1 << 9); reg_we = 1'b1;
    #1 check("R6 before enable edge", irq_o[9], 1'b0);
    @(posedge clk);
    #1 check("R6 after enable edge", irq_o[9], 1'b1);
    @(negedge clk);
    reg_we = 1'b0;
    wr(12'h010, en0);
    pin_i[9] = 1'b0;

    // R8 R9 R10 R11 sleep, latch, wake, replay
    wr(12'h110 + 12'd12, 32'd6);
    wr(12'h110 + 12'd4 * 12'd34, 32'd2);
    wr(12'h014, 32'd1 << 2);
    pin_i[34] = 1'b1;
    cyc(4);
    check("R9 no wake while awake", wake_o, 1'b0);
    dom_sleep = 1'b1;
    cyc(3);
    check("R9 no wake without source", wake_o, 1'b0);
    pin_i[3] = 1'b1; pin_i[34] = 1'b0; pin_i[5] = 1'b1;
    for (int k = 0; k < 6; k++) begin
      cyc(1);
      check("R8 no live edge in sleep", {irq_o[34], irq_o[5], irq_o[3]}, 3'b000);
    end
    check("R9 wake raised", wake_o, 1'b1);
    dom_sleep = 1'b0; dom_ready = 1'b1;
    p3 = -1; p34 = -1; order_ok = 1;
    for (int k = 0; k < 5; k++) begin
      if (k > 0) @(negedge clk);
      #1;
      if (irq_o[3]) begin if (p3 >= 0) order_ok = 0; p3 = k; end
      if (irq_o[34]) begin if (p34 >= 0) order_ok = 0; p34 = k; end
      check("R6 disabled pin not replayed", irq_o[5], 1'b0);
      if (k == 1) check("R10 wake cleared", wake_o, 1'b0);
    end
    check("R11 pin3 replayed first cycle", p3, 0);
    check("R11 pin34 replayed second cycle", p34, 1);
    check("R11 one pulse per pin", order_ok, 1);
    dom_ready = 1'b0;
    cyc(2);
    check("R11 replay drained", irq_o, '0);

    // R9 R10 level source wakes, ready clears with priority
    wr(12'h110 + 12'd28, 32'd0);
    pin_i[7] = 1'b1;
    en0 = en0 | (1 << 7);
    wr(12'h010, en0);
    cyc(3);
    check("R2 inverted level idle", irq_o[7], 1'b0);
    dom_sleep = 1'b1;
    cyc(3);
    check("R9 no wake idle level", wake_o, 1'b0);
    pin_i[7] = 1'b0;
    cyc(2);
    check("R2 inverted level active", irq_o[7], 1'b1);
    cyc(1);
    check("R9 wake from level", wake_o, 1'b1);
    dom_ready = 1'b1;
    cyc(1);
    check("R10 ready clears over set", wake_o, 1'b0);
    dom_sleep = 1'b0; dom_ready = 1'b0;
    cyc(2);
    check("R10 wake stays low awake", wake_o, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule